// File: doc/BRIEF.md
# Radix-2^k Montgomery Modular Multiplier

This block multiplies two residues a and b modulo an odd modulus m and returns (a·b·2^-WIDTH) mod m. The operand width WIDTH is split into NDIG = WIDTH/DIGIT digits of DIGIT bits. The caller also supplies a digit constant: the inverse of -m modulo 2^DIGIT. The block holds a running partial sum S, which is cleared when an operation is accepted.

Each cycle the block consumes one digit of a, least significant digit first. It adds a_i·b to S, then adds q_i·m. The quotient digit q_i is chosen so that the low DIGIT bits of the total become zero. The total is then shifted right by DIGIT bits. The quotient digit is the low DIGIT bits of (S + a_i·b) multiplied by the constant, again keeping only the low DIGIT bits. The inverse of 2^DIGIT is never formed. After the last digit, one correction cycle subtracts m when S ≥ m.

The block is used in exponentiation engines that keep operands in this scaled form. Computing the constants and driving the exponent loop are left to the surrounding logic.

Top module: `mont_mul`

## Requirements
- R1: After synchronous reset, `ready` and `busy` are 0 and `result` is 0.
- R2: `start` is accepted only while `busy` is 0. It captures `a_in`, `b_in`, `m_in` and `minv_in`, and `busy` is 1 in the following cycle.
- R3: For odd m, a < m, b < m and minv_in = (-m)^-1 mod 2^DIGIT, `result` satisfies result·2^WIDTH ≡ a·b (mod m).
- R4: In every recursion the sum S + a_i·b + q_i·m has its low DIGIT bits equal to zero.
- R5: The partial result S stays below 2·m throughout an operation.
- R6: When `ready` is 1, `result` is strictly below m, including when a = b = m-1.
- R7: `ready` is 1 for exactly one cycle, NDIG+1 clock edges after the edge that accepted `start`. `busy` is 0 in that cycle.
- R8: `start` asserted while `busy` is 1 has no effect. The captured operands are unchanged, and the result belongs to the operation already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication (taken when idle) |
| a_in | input | WIDTH | Multiplier operand, consumed digit by digit |
| b_in | input | WIDTH | Multiplicand operand |
| m_in | input | WIDTH | Odd modulus |
| minv_in | input | DIGIT | Inverse of -m modulo 2^DIGIT |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | One-cycle pulse: `result` is valid |
| result | output | WIDTH | Fully reduced product, held until the next result |

## Verification
`busy` is checked one cycle after the accepting edge. `ready` is expected exactly NDIG+1 edges after that same edge. The bench counts falling edges from the accepting edge and compares the count against NDIG+1. It then reads `result` in that cycle and confirms on the next falling edge that `ready` has dropped.

The sweep is run for a small configuration: WIDTH 6 and DIGIT 2, so results are due four edges after acceptance. The expected residue is found arithmetically as the unique y < m with y·2^WIDTH ≡ a·b. One operation per modulus repeats `start` with different operands while the block is busy. The result of that operation must still match the first operands.

// File: rtl/mont_pkg.sv
package mont_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mont_state_e;

    // digits consumed per operation
    function automatic int digit_count(input int width, input int digit);
        return width / digit;
    endfunction

endpackage

// File: rtl/mont_qsel.sv
// Quotient digit: low DIGIT bits of (S + a_i*b) times the inverse digit.
module mont_qsel #(
    parameter int DIGIT = 4
) (
    input  logic [DIGIT-1:0] s_lo,
    input  logic [DIGIT-1:0] a_dig,
    input  logic [DIGIT-1:0] b_lo,
    input  logic [DIGIT-1:0] minv,
    output logic [DIGIT-1:0] q
);
    logic [DIGIT-1:0] t_lo;

    assign t_lo = s_lo + a_dig * b_lo;

    generate
        if (DIGIT == 1) begin : g_bin
            // for one-bit digits the inverse is always 1
            logic unused_minv;
            assign unused_minv = minv[0];
            assign q = t_lo;
        end else begin : g_rad
            assign q = t_lo * minv;
        end
    endgenerate
endmodule

// File: rtl/mont_step.sv
// One recursion: S + a_i*b + q_i*m, then drop the DIGIT cleared bits.
module mont_step #(
    parameter int WIDTH = 16,
    parameter int DIGIT = 4
) (
    input  logic [WIDTH:0]           s,
    input  logic [DIGIT-1:0]         a_dig,
    input  logic [WIDTH-1:0]         b,
    input  logic [WIDTH-1:0]         m,
    input  logic [DIGIT-1:0]         q,
    output logic [WIDTH+DIGIT:0]     sum,
    output logic [WIDTH:0]           s_next
);
    localparam int WS = WIDTH + DIGIT + 1;

    assign sum    = WS'(s) + WS'(a_dig) * WS'(b) + WS'(q) * WS'(m);
    assign s_next = sum[WS-1:DIGIT];
endmodule

// File: rtl/mont_fix.sv
// Final correction: one conditional subtraction of m.
module mont_fix #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH:0]   s,
    input  logic [WIDTH-1:0] m,
    output logic [WIDTH-1:0] res
);
    logic [WIDTH:0] m_ext;
    logic           ge;

    assign m_ext = {1'b0, m};
    assign ge    = (s >= m_ext);
    assign res   = ge ? WIDTH'(s - m_ext) : s[WIDTH-1:0];
endmodule

// File: rtl/mont_mul.sv
module mont_mul
    import mont_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIGIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] m_in,
    input  logic [DIGIT-1:0] minv_in,
    output logic             busy,
    output logic             ready,
    output logic [WIDTH-1:0] result
);
    localparam int NDIG = digit_count(WIDTH, DIGIT);
    localparam int CW   = $clog2(NDIG + 1);
    localparam int WS   = WIDTH + DIGIT + 1;

    typedef struct packed {
        logic [WIDTH-1:0] a_sh;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] m;
        logic [DIGIT-1:0] minv;
    } opnd_t;

    mont_state_e      st;
    logic [CW-1:0]    cnt;
    opnd_t            op_q;
    logic [WIDTH-1:0] m_q;
    logic [WIDTH:0]   s_q;
    logic [WIDTH-1:0] res_q;
    logic             rdy_q;

    logic [DIGIT-1:0] q_dig;
    logic [WS-1:0]    step_sum;
    logic [WIDTH:0]   s_nxt;
    logic [WIDTH-1:0] fix_out;

    assign m_q = op_q.m;

    mont_qsel #(.DIGIT(DIGIT)) u_qsel (
        .s_lo  (s_q[DIGIT-1:0]),
        .a_dig (op_q.a_sh[DIGIT-1:0]),
        .b_lo  (op_q.b[DIGIT-1:0]),
        .minv  (op_q.minv),
        .q     (q_dig)
    );

    mont_step #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_step (
        .s      (s_q),
        .a_dig  (op_q.a_sh[DIGIT-1:0]),
        .b      (op_q.b),
        .m      (op_q.m),
        .q      (q_dig),
        .sum    (step_sum),
        .s_next (s_nxt)
    );

    mont_fix #(.WIDTH(WIDTH)) u_fix (
        .s   (s_q),
        .m   (op_q.m),
        .res (fix_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            op_q  <= '0;
            s_q   <= '0;
            res_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_q.a_sh <= a_in;
                        op_q.b    <= b_in;
                        op_q.m    <= m_in;
                        op_q.minv <= minv_in;
                        s_q       <= '0;
                        cnt       <= '0;
                        st        <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    s_q       <= s_nxt;
                    op_q.a_sh <= op_q.a_sh >> DIGIT;
                    cnt       <= cnt + 1'b1;
                    if (cnt == CW'(NDIG - 1)) st <= ST_FIX;
                end
                ST_FIX: begin
                    res_q <= fix_out;
                    rdy_q <= 1'b1;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st != ST_IDLE);
    assign ready  = rdy_q;
    assign result = res_q;
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
    parameter int WIDTH = 16,
    parameter int DIGIT = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   ready,
    input logic [WIDTH-1:0]       result,
    input logic [WIDTH-1:0]       m_q,
    input logic [WIDTH:0]         s_q,
    input logic [WIDTH+DIGIT:0]   step_sum
);
    localparam int NDIG = WIDTH / DIGIT;
    localparam int LW   = $clog2(NDIG + 2) + 1;

    logic [LW-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst)                lat <= '0;
        else if (start && !busy) lat <= '0;
        else if (busy)          lat <= lat + 1'b1;
    end

    assert_low_clear_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_sum[DIGIT-1:0] == '0));

    assert_partial_bound_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (s_q < ({1'b0, m_q} << 1)));

    assert_reduced_R6: assert property (@(posedge clk) disable iff (rst)
        ready |-> (result < m_q));

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> (lat == LW'(NDIG + 1)));

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_no_reload_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(m_q));
endmodule

bind mont_mul mont_mul_chk #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .ready    (ready),
    .result   (result),
    .m_q      (m_q),
    .s_q      (s_q),
    .step_sum (step_sum)
);

// File: tb/tb_mont_mul.sv
module tb_mont_mul;
    localparam int W    = 6;
    localparam int K    = 2;
    localparam int NDIG = W / K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, m_in = '0;
    logic [K-1:0] minv_in = '0;
    logic         busy, ready;
    logic [W-1:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mont_mul #(.WIDTH(W), .DIGIT(K)) dut (
        .clk(clk), .rst(rst), .start(start),
        .a_in(a_in), .b_in(b_in), .m_in(m_in), .minv_in(minv_in),
        .busy(busy), .ready(ready), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int inv_digit(input int m);
        for (int x = 0; x < (1 << K); x++)
            if (((m * x) % (1 << K)) == (1 << K) - 1) return x;
        return 0;
    endfunction

    function automatic int mont_ref(input int a, input int b, input int m);
        longint tgt = (longint'(a) * b) % m;
        for (int y = 0; y < m; y++)
            if (((longint'(y) << W) % m) == tgt) return y;
        return -1;
    endfunction

    task automatic do_op(input int a, input int b, input int m, input bit inject);
        int cyc;
        int exp;
        exp = mont_ref(a, b, m);
        @(negedge clk);
        a_in = W'(a); b_in = W'(b); m_in = W'(m); minv_in = K'(inv_digit(m));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
        cyc = 0;
        if (inject) begin
            // R8: second request while busy must be ignored
            a_in = W'(m - 1); b_in = W'(1); m_in = W'(m == 3 ? 5 : 3);
            minv_in = K'(inv_digit(m == 3 ? 5 : 3));
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc = 1;
        end
        while (!ready && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == NDIG + 1, "R7 latency", cyc, NDIG + 1);
        check(int'(result) == exp, inject ? "R8 result of running op" : "R3 product",
              int'(result), exp);
        check(int'(result) < m, "R6 result below m", int'(result), m);
        check(busy == 1'b0, "R7 busy low with ready", busy, 0);
        @(negedge clk);
        check(ready == 1'b0, "R7 single-cycle pulse", ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b0, "R1 ready after reset", ready, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(result == '0, "R1 result after reset", int'(result), 0);

        // R3/R6 corner: largest operands
        do_op(62, 62, 63, 1'b0);
        do_op(0, 5, 7, 1'b0);

        for (int m = 3; m < (1 << W); m += 2) begin
            int stp;
            stp = (m < 32) ? 1 : 3;
            do_op(m - 1, m - 2, m, 1'b1);
            for (int a = 0; a < m; a += stp)
                for (int b = 0; b < m; b += stp)
                    do_op(a, b, m, 1'b0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule